// File: doc/BRIEF.md
# Serial Converter Capture Sequencer with Ring Buffer

This block collects conversion results from a chain of dual-channel serial converters and keeps them in an on-chip circular buffer. When the converter chain pulls its active-low ready line down, the sequencer waits a programmed number of system-clock cycles and then drops its active-low transmit request. It then generates a data clock, shifts in one 20-bit sample per channel for every device in the chain, and stores each sample as a 24-bit word that also carries a side flag. The side flag toggles once per conversion frame, so a host can tell which integration side a word came from.

The buffer has a single pointer. In capture mode each stored word lands at the pointer, which then moves up by one and wraps, so the oldest words are overwritten. In readback mode serial frames still run, but nothing is written. The host then steps the pointer down one word at a time, newest first, and reads the addressed word on a registered output. Each word reaches memory as three byte-lane writes. A change of mode during a word takes effect only after that word's writes are complete.

Top module: `adc_ring_capture`

## Requirements
- R1: The transmit request `xmit_n` goes low exactly N clock edges after the first edge that sees `ready_n` low following a high sample, where N is `delay_cfg`. A value of 0 acts as 1. A falling `ready_n` that arrives while a frame is in progress is ignored and starts no new frame.
- R2: Each bit is one `dclk` pulse, high for one clock cycle and then low for one. `sdata` is sampled on the edge where `dclk` falls. The most significant bit of a sample arrives first, and every word has exactly 20 pulses.
- R3: A frame carries two words per device, and `dev_cfg` sets the number of devices. A value of 0 acts as 1, and any value above 64 acts as 64.
- R4: `xmit_n` stays low until the last bit of the frame has been sampled and goes high on the next clock edge.
- R5: A stored word holds the sample in bits 19:0 and the side flag in bit 22. Bits 23, 21 and 20 are zero.
- R6: The side flag is 1 (side A) for the first frame after reset and inverts at the end of every frame, in either mode.
- R7: In capture mode each word is written at the pointer, and the pointer then increases by one, wrapping from 2^ADDR_W-1 to 0.
- R8: In readback mode, frames still produce clock pulses but write nothing to memory and do not move the pointer.
- R9: In readback mode, a one-cycle `rd_step` decrements the pointer, wrapping from 0 to 2^ADDR_W-1. Two clock edges after the step, `rd_word` shows the word at the new pointer. In capture mode `rd_step` has no effect.
- R10: A change of `capture_en` during a word's transfer first governs the next word. The current word is stored or skipped according to the mode in force when its transfer began.
- R11: During reset, `xmit_n` is 1, `dclk` is 0 and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | 1 selects capture mode, 0 selects readback mode |
| delay_cfg | input | 9 | Delay in clock cycles from the ready fall to the transmit request |
| dev_cfg | input | 7 | Number of devices in the chain |
| ready_n | input | 1 | Active-low data-ready line from the converters |
| sdata | input | 1 | Serial data from the converters |
| xmit_n | output | 1 | Active-low transmit request to the converters |
| dclk | output | 1 | Data clock to the converters |
| rd_step | input | 1 | One-cycle pulse that moves the pointer back one word (readback mode only) |
| rd_word | output | 24 | Word stored at the current pointer, registered |

## Verification
The hardest case to reach from the ports is a mode change that falls inside a word's transfer. Whether it was honoured only shows later, through which buffer slots hold new data. The bench switches `capture_en` while `dclk` is high for the first bit of a word, lets the frame finish, and then walks the pointer back through every slot. It checks that the first word left the old contents untouched and that the following words were stored. Pointer wrap in both directions is reached by shrinking the buffer to 16 entries, capturing 18 words, and reading back a full turn of the ring.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT, ST_STORE} arc_state_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/arc_delay_timer.sv
module arc_delay_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= (limit == '0) ? W'(1) : limit;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == W'(1));

  AST_DLY_LOADED: assert property (@(posedge clk) disable iff (rst) start |=> (cnt != '0));  // R1
  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst) (expire && !start) |=> !expire);  // R1
endmodule

// File: rtl/arc_serial_shifter.sv
module arc_serial_shifter #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                sdata,
  output logic                dclk,
  output logic [SAMPLE_W-1:0] word,
  output logic                done
);
  localparam int BIT_W = $clog2(SAMPLE_W);

  logic             active;
  logic             phase;
  logic [BIT_W-1:0] bitcnt;
  logic             last_bit;

  assign last_bit = (bitcnt == BIT_W'(SAMPLE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= 1'b0;
      bitcnt <= '0;
      dclk   <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        phase  <= 1'b0;
        bitcnt <= '0;
      end else if (active) begin
        if (!phase) begin
          dclk  <= 1'b1;
          phase <= 1'b1;
        end else begin
          dclk  <= 1'b0;
          phase <= 1'b0;
          word  <= {word[SAMPLE_W-2:0], sdata};
          if (last_bit) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

  AST_DCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !active |=> !dclk);  // R2
  AST_DCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) dclk |=> !dclk);  // R2
endmodule

// File: rtl/arc_ring_store.sv
module arc_ring_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [LANES-1:0]                   we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [LANES*arc_pkg::BYTE_W-1:0]   wdata,
  output logic [LANES*arc_pkg::BYTE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = arc_pkg::BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] bank [DEPTH];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) bank[addr] <= wdata[g*BW +: BW];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= bank[addr];
    end

    assign rdata[g*BW +: BW] = rd_q;
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst) $onehot0(we));  // R7
endmodule

// File: rtl/adc_ring_capture.sv
module adc_ring_capture #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 20,
  parameter int DLY_W    = 9,
  parameter int DEV_W    = 7,
  parameter int MAX_DEV  = 64,
  parameter int WORD_W   = 24,
  parameter int SIDE_BIT = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_en,
  input  logic [DLY_W-1:0]  delay_cfg,
  input  logic [DEV_W-1:0]  dev_cfg,
  input  logic              ready_n,
  input  logic              sdata,
  output logic              xmit_n,
  output logic              dclk,
  input  logic              rd_step,
  output logic [WORD_W-1:0] rd_word
);
  import arc_pkg::*;

  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = DEV_W + 1;

  arc_state_t          state;
  logic                rdy_q;
  logic                eff_cap;
  logic                side;
  logic [ADDR_W-1:0]   ptr;
  logic [CNT_W-1:0]    word_idx;
  logic [CNT_W-1:0]    word_total;
  logic [LANE_W-1:0]   lane;
  logic [DEV_W-1:0]    dev_c;
  logic                fall;
  logic                expire;
  logic                sh_go;
  logic                sh_done;
  logic [SAMPLE_W-1:0] sh_word;
  logic                lane_last;
  logic                word_last;
  logic [WORD_W-1:0]   wr_word;
  logic [LANES-1:0]    we;

  assign fall      = rdy_q & ~ready_n;
  assign lane_last = (lane == LANE_W'(LANES - 1));
  assign word_last = (word_idx == word_total - 1'b1);

  always_comb begin
    if (dev_cfg == '0)                     dev_c = DEV_W'(1);
    else if (dev_cfg > DEV_W'(MAX_DEV))    dev_c = DEV_W'(MAX_DEV);
    else                                   dev_c = dev_cfg;
  end

  always_comb begin
    wr_word                  = '0;
    wr_word[SAMPLE_W-1:0]    = sh_word;
    wr_word[SIDE_BIT]        = side;
  end

  always_comb begin
    we = '0;
    if (state == ST_STORE && eff_cap) we[lane] = 1'b1;
  end

  assign sh_go = (state == ST_WAIT && expire) ||
                 (state == ST_STORE && lane_last && !word_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      xmit_n     <= 1'b1;
      rdy_q      <= 1'b1;
      eff_cap    <= 1'b0;
      side       <= 1'b1;
      ptr        <= '0;
      word_idx   <= '0;
      word_total <= '0;
      lane       <= '0;
    end else begin
      rdy_q <= ready_n;
      if (rd_step && !eff_cap) ptr <= ptr - 1'b1;
      case (state)
        ST_IDLE: begin
          eff_cap <= capture_en;
          if (fall) begin
            state      <= ST_WAIT;
            word_idx   <= '0;
            word_total <= {dev_c, 1'b0};
          end
        end
        ST_WAIT: begin
          eff_cap <= capture_en;
          if (expire) begin
            state  <= ST_SHIFT;
            xmit_n <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            state <= ST_STORE;
            lane  <= '0;
            if (word_last) xmit_n <= 1'b1;
          end
        end
        default: begin
          lane <= lane + 1'b1;
          if (lane_last) begin
            eff_cap <= capture_en;
            if (eff_cap) ptr <= ptr + 1'b1;
            if (word_last) begin
              state <= ST_IDLE;
              side  <= ~side;
            end else begin
              state    <= ST_SHIFT;
              word_idx <= word_idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

  arc_delay_timer #(.W(DLY_W)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (state == ST_IDLE && fall),
    .limit  (delay_cfg),
    .expire (expire)
  );

  arc_serial_shifter #(.SAMPLE_W(SAMPLE_W)) i_shift (
    .clk   (clk),
    .rst   (rst),
    .go    (sh_go),
    .sdata (sdata),
    .dclk  (dclk),
    .word  (sh_word),
    .done  (sh_done)
  );

  arc_ring_store #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ring (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .addr  (ptr),
    .wdata (wr_word),
    .rdata (rd_word)
  );

  AST_PTR_FORWARD: assert property (@(posedge clk) disable iff (rst) eff_cap |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));  // R7
  AST_PTR_BACKWARD: assert property (@(posedge clk) disable iff (rst) !eff_cap |=> (ptr == $past(ptr) || ptr == $past(ptr) - 1'b1));  // R8
  AST_XMIT_DURING_CLOCK: assert property (@(posedge clk) disable iff (rst) dclk |-> !xmit_n);  // R4
  AST_NO_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst) !eff_cap |-> (we == '0));  // R8
endmodule

// File: tb/test_adc_ring_capture.sv
module test_adc_ring_capture;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int SW    = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        capture_en = 1'b0;
  logic [8:0]  delay_cfg = '0;
  logic [6:0]  dev_cfg = '0;
  logic        ready_n = 1'b1;
  logic        sdata = 1'b0;
  logic        xmit_n;
  logic        dclk;
  logic        rd_step = 1'b0;
  logic [23:0] rd_word;

  int n_chk = 0;
  int n_bad = 0;

  logic [23:0] mdl_mem [DEPTH];
  bit          mdl_ok  [DEPTH];
  int          mdl_ptr = 0;
  bit          mdl_side = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ring_capture #(.ADDR_W(AW)) i_adc_ring_capture (
    .clk(clk), .rst(rst), .capture_en(capture_en), .delay_cfg(delay_cfg),
    .dev_cfg(dev_cfg), .ready_n(ready_n), .sdata(sdata), .xmit_n(xmit_n),
    .dclk(dclk), .rd_step(rd_step), .rd_word(rd_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] sample(input int seed, input int wi);
    return 20'((seed * 40503 + wi * 2654435 + 977) ^ (wi << 7));
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // One conversion frame driven from the converter side, with model update.
  task automatic run_frame(input int ndev, input int dly, input bit sw_en, input int sw_word,
                           input bit sw_val, input bit poke_rdy, input int seed);
    int nw, k, eff_n;
    bit cap;
    logic [19:0] val;
    logic [23:0] w;
    nw    = 2 * ((ndev == 0) ? 1 : ((ndev > 64) ? 64 : ndev));
    eff_n = (dly == 0) ? 1 : dly;
    delay_cfg = 9'(dly);
    dev_cfg   = 7'(ndev);
    @(negedge clk);
    cap = capture_en;
    ready_n = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (xmit_n !== 1'b0 && k < 2000);
    chk("R1 delay", 32'(k), 32'(eff_n + 1));
    for (int wi = 0; wi < nw; wi++) begin
      val = sample(seed, wi);
      for (int b = SW - 1; b >= 0; b--) begin
        while (dclk !== 1'b1) @(negedge clk);
        sdata = val[b];
        if (sw_en && wi == sw_word && b == SW - 1) capture_en = sw_val;
        if (poke_rdy && wi == 0 && b == 10) ready_n = 1'b1;
        if (poke_rdy && wi == 1 && b == 10) ready_n = 1'b0;
        @(negedge clk);
        if (wi == 0 && b == 0) chk("R2 dclk low after one cycle", 32'(dclk), 32'd0);
      end
      w = 24'(val);
      w[22] = mdl_side;
      if (cap) begin
        mdl_mem[mdl_ptr] = w;
        mdl_ok[mdl_ptr]  = 1'b1;
        mdl_ptr = (mdl_ptr + 1) % DEPTH;
      end
      if (sw_en && wi == sw_word) cap = sw_val;
      if (wi == nw - 1) begin
        chk("R4 xmit low at last sample", 32'(xmit_n), 32'd0);
        @(negedge clk);
        chk("R3 frame ends after expected words", 32'(xmit_n), 32'd1);
      end
    end
    mdl_side = ~mdl_side;
    if (poke_rdy) begin
      repeat (eff_n + 5) @(negedge clk);
      chk("R1 fall mid-frame ignored", 32'(xmit_n), 32'd1);
    end
    repeat (4) @(negedge clk);
    ready_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rb_steps(input int n, input string tag);
    capture_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rd_step = 1'b1;
      @(negedge clk);
      rd_step = 1'b0;
      @(negedge clk);
      mdl_ptr = (mdl_ptr + DEPTH - 1) % DEPTH;
      if (mdl_ok[mdl_ptr]) begin
        chk(tag, 32'(rd_word), 32'(mdl_mem[mdl_ptr]));
        chk("R6 side flag", 32'(rd_word[22]), 32'(mdl_mem[mdl_ptr][22]));
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 xmit_n", 32'(xmit_n), 32'd1);
    chk("R11 dclk", 32'(dclk), 32'd0);
    chk("R11 rd_word", 32'(rd_word), 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic();
    capture_en = 1'b1;
    run_frame(2, 5, 1'b0, 0, 1'b0, 1'b0, 11);
    rb_steps(4, "R5 word format");
  endtask

  task automatic t_delays();
    capture_en = 1'b1;
    run_frame(1, 0, 1'b0, 0, 1'b0, 1'b0, 21);
    run_frame(1, 300, 1'b0, 0, 1'b0, 1'b0, 22);
    run_frame(1, 1, 1'b0, 0, 1'b0, 1'b1, 23);
  endtask

  task automatic t_devcount();
    capture_en = 1'b1;
    run_frame(0, 3, 1'b0, 0, 1'b0, 1'b0, 31);
    run_frame(100, 2, 1'b0, 0, 1'b0, 1'b0, 32);
  endtask

  task automatic t_step_ignored();
    capture_en = 1'b1;
    run_frame(1, 2, 1'b0, 0, 1'b0, 1'b0, 41);
    repeat (3) begin
      rd_step = 1'b1;
      @(negedge clk);
      rd_step = 1'b0;
      @(negedge clk);
    end
    rb_steps(1, "R9 step ignored while capturing");
  endtask

  task automatic t_wrap();
    capture_en = 1'b1;
    run_frame(3, 2, 1'b0, 0, 1'b0, 1'b0, 51);
    run_frame(3, 2, 1'b0, 0, 1'b0, 1'b0, 52);
    run_frame(3, 2, 1'b0, 0, 1'b0, 1'b0, 53);
    rb_steps(DEPTH, "R7 ring wrap");
    rb_steps(3, "R9 pointer decrement wrap");
  endtask

  task automatic t_readback_frame();
    capture_en = 1'b1;
    run_frame(3, 2, 1'b0, 0, 1'b0, 1'b0, 61);
    capture_en = 1'b0;
    run_frame(3, 2, 1'b0, 0, 1'b0, 1'b0, 62);
    rb_steps(6, "R8 readback frame writes nothing");
  endtask

  task automatic t_mode_switch();
    capture_en = 1'b1;
    run_frame(2, 2, 1'b0, 0, 1'b0, 1'b0, 71);
    capture_en = 1'b0;
    run_frame(2, 2, 1'b1, 0, 1'b1, 1'b0, 72);
    rb_steps(4, "R10 mode change after current word");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl_ok[i] = 1'b0;
    t_reset();
    t_basic();
    t_delays();
    t_devcount();
    t_step_ignored();
    t_wrap();
    t_readback_frame();
    t_mode_switch();
    summary();
  end
endmodule